// File: doc/BRIEF.md
# Phase-Offset Clock Output Divider

This block produces several divided clock waveforms from one fast synchronous timebase, each with its own programmable phase offset. Eight consecutive fast-clock ticks represent one period of a modelled oscillator, and each tick stands for one of eight evenly spaced oscillator phases. Every channel divides by a programmable count of oscillator periods. Its first rising edge is pushed back by a whole number of oscillator periods (the coarse start count) plus a number of eighth-period steps (the fine tap).

The design has `N_OUT` output channels and one extra feedback channel. The feedback channel sits at the highest index and behaves exactly like the output channels. Configuration is taken only while reset is held. A sticky locked flag reports that every enabled channel has finished its start delay. Uses include clock-phase alignment studies and gated-clock enables inside a synchronous design.

Top module: `phase_offset_divider`

## Requirements
- R1: While `rst` is high, every `clk_out` bit and `locked` are low after each clock edge. The configuration inputs are captured on every rising edge that sees `rst` high, so the values present at the last reset edge are the ones that take effect.
- R2: Let tick 0 be the first rising edge with `rst` low. A channel with start count C and tap k stays low through ticks before (C-1)*8+k and goes high after that tick.
- R3: Each step of the 3-bit fine tap, `cfg_tap[3*i +: 3]`, delays channel i by exactly one tick. A start count of 1 with a tap of 0 gives high right after tick 0.
- R4: Once started, a channel with divide value D repeats with a period of 8*D ticks. D is taken from `cfg_div[DIV_W*i +: DIV_W]`.
- R5: Each period begins with a high time of 8*ceil(D/2) ticks and is low for the rest. With D = 1 the output therefore stays high.
- R6: A divide value of 0 acts as 1, and a start count of 0 acts as 1. The start count is taken from `cfg_start[CNT_W*i +: CNT_W]`.
- R7: A channel whose bit `cfg_en[i]` is 0 at the last reset edge keeps `clk_out[i]` low until the next reset.
- R8: `locked` goes high after the tick equal to the largest start delay among enabled channels, or after tick 0 if none is enabled. It then stays high until reset.
- R9: Changes on the configuration inputs while `rst` is low have no effect on any output until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast timebase, eight ticks per modelled oscillator period |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_en | input | N_OUT+1 | Per-channel enable; the top bit is the feedback channel |
| cfg_div | input | (N_OUT+1)*DIV_W | Per-channel divide value in oscillator periods |
| cfg_start | input | (N_OUT+1)*CNT_W | Per-channel coarse start count C |
| cfg_tap | input | (N_OUT+1)*3 | Per-channel fine phase tap |
| clk_out | output | N_OUT+1 | Registered divided waveforms |
| locked | output | 1 | Sticky flag: all enabled channels have started |

## Verification
The bench aims at the start boundary: zero delay, the maximum tap of 7, and a maximum coarse count. A design that fires one tick early or late, or treats the coarse count as C instead of C-1, shows up on the first edge. Odd and even divide values and D = 1 test the rounding of the high time; a wrong rounding gives a short pulse or an output that toggles when it should stay high. Zero-valued settings, disabled channels and an all-disabled set test the clamps and the lock rule, which could otherwise lock too early or never. Configuration writes during a run and shortly before the end of reset show whether values leak in outside the capture window.

// File: rtl/phase_div_pkg.sv
package phase_div_pkg;
  localparam int TAP_W  = 3;
  localparam int PHASES = 1 << TAP_W;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } ch_state_e;
endpackage

// File: rtl/pdiv_cfg_latch.sv
module pdiv_cfg_latch
  import phase_div_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [DW-1:0]    div_i,
  input  logic [CW-1:0]    start_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             en_q,
  output logic [DW-1:0]    div_q,
  output logic [CW-1:0]    start_q,
  output logic [TAP_W-1:0] tap_q
);
  // capture window is the reset interval only; zero values clamp to one
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= en_i;
      div_q   <= (div_i == '0) ? DW'(1) : div_i;
      start_q <= (start_i == '0) ? CW'(1) : start_i;
      tap_q   <= tap_i;
    end
  end
endmodule

// File: rtl/pdiv_start_delay.sv
module pdiv_start_delay
  import phase_div_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    start_q,
  input  logic [TAP_W-1:0] tap_q,
  output logic             fire,
  output logic             running
);
  localparam int WW = CW + TAP_W;

  ch_state_e     state;
  logic [WW-1:0] cnt;
  logic [WW-1:0] target;

  // coarse periods form the upper bits, the fine tap the lower three
  assign target  = {start_q - CW'(1), tap_q};
  assign fire    = (state == ST_HOLD) && (cnt == target);
  assign running = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HOLD;
      cnt   <= '0;
    end else if (state == ST_HOLD) begin
      if (fire) state <= ST_RUN;
      else      cnt   <= cnt + WW'(1);
    end
  end
endmodule

// File: rtl/pdiv_wave_gen.sv
module pdiv_wave_gen
  import phase_div_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_q,
  input  logic [DW-1:0] div_q,
  input  logic          fire,
  input  logic          running,
  output logic          wave
);
  localparam int PW = DW + TAP_W + 1;

  logic [DW:0]   half;
  logic [PW-1:0] hi_ticks;
  logic [PW-1:0] per_ticks;
  logic [PW-1:0] ph;

  assign half      = ({1'b0, div_q} + (DW+1)'(1)) >> 1;
  assign hi_ticks  = PW'(half) * PW'(PHASES);
  assign per_ticks = PW'(div_q) * PW'(PHASES);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      wave <= 1'b0;
    end else if (fire) begin
      wave <= en_q;
      ph   <= PW'(1);
    end else if (running) begin
      wave <= en_q && (ph < hi_ticks);
      ph   <= (ph == per_ticks - PW'(1)) ? '0 : ph + PW'(1);
    end
  end
endmodule

// File: rtl/pdiv_lock.sv
module pdiv_lock #(
  parameter int N_CH = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] en_q,
  input  logic [N_CH-1:0] go,
  output logic            locked
);
  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b0;
    else     locked <= locked | (&(go | ~en_q));
  end
endmodule

// File: rtl/phase_offset_divider.sv
module phase_offset_divider
  import phase_div_pkg::*;
#(
  parameter int N_OUT = 5,
  parameter int DIV_W = 8,
  parameter int CNT_W = 8,
  localparam int N_CH = N_OUT + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_CH-1:0]        cfg_en,
  input  logic [N_CH*DIV_W-1:0]  cfg_div,
  input  logic [N_CH*CNT_W-1:0]  cfg_start,
  input  logic [N_CH*TAP_W-1:0]  cfg_tap,
  output logic [N_CH-1:0]        clk_out,
  output logic                   locked
);
  logic [N_CH-1:0] en_q;
  logic [N_CH-1:0] fire_v;
  logic [N_CH-1:0] run_v;

  // channel N_OUT is the feedback counter; same datapath as the outputs
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] start_q;
    logic [TAP_W-1:0] tap_q;

    pdiv_cfg_latch #(.DW(DIV_W), .CW(CNT_W)) u_cfg (
      .clk(clk), .rst(rst),
      .en_i(cfg_en[g]),
      .div_i(cfg_div[g*DIV_W +: DIV_W]),
      .start_i(cfg_start[g*CNT_W +: CNT_W]),
      .tap_i(cfg_tap[g*TAP_W +: TAP_W]),
      .en_q(en_q[g]), .div_q(div_q), .start_q(start_q), .tap_q(tap_q)
    );

    pdiv_start_delay #(.CW(CNT_W)) u_dly (
      .clk(clk), .rst(rst),
      .start_q(start_q), .tap_q(tap_q),
      .fire(fire_v[g]), .running(run_v[g])
    );

    pdiv_wave_gen #(.DW(DIV_W)) u_wave (
      .clk(clk), .rst(rst),
      .en_q(en_q[g]), .div_q(div_q),
      .fire(fire_v[g]), .running(run_v[g]),
      .wave(clk_out[g])
    );
  end

  pdiv_lock #(.N_CH(N_CH)) u_lock (
    .clk(clk), .rst(rst),
    .en_q(en_q), .go(fire_v | run_v),
    .locked(locked)
  );
endmodule

// File: rtl/phase_div_chk.sv
module phase_div_chk #(
  parameter int N_CH = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CH-1:0] clk_out,
  input logic            locked,
  input logic [N_CH-1:0] en_q,
  input logic [N_CH-1:0] run_v
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (clk_out == '0 && !locked));

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R8
  lock_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (&(run_v | ~en_q)));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(en_q));

  for (genvar g = 0; g < N_CH; g++) begin : g_off
    // R7
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
      !en_q[g] |-> !clk_out[g]);
  end
endmodule

bind phase_offset_divider phase_div_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .clk_out(clk_out), .locked(locked),
  .en_q(en_q), .run_v(run_v)
);

// File: tb/tb_phase_offset_divider.sv
module tb_phase_offset_divider;
  localparam int CLK_PERIOD = 10;
  localparam int N_OUT = 5;
  localparam int N_CH  = N_OUT + 1;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_CH-1:0]    cfg_en;
  logic [N_CH*DW-1:0] cfg_div;
  logic [N_CH*CW-1:0] cfg_start;
  logic [N_CH*TW-1:0] cfg_tap;
  logic [N_CH-1:0]    clk_out;
  logic               locked;

  int b_en[N_CH], b_div[N_CH], b_c[N_CH], b_k[N_CH];
  int m_en[N_CH], m_div[N_CH], m_c[N_CH], m_k[N_CH];
  int t = -1;
  int n_chk = 0, n_fail = 0;

  phase_offset_divider #(.N_OUT(N_OUT), .DIV_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_div(cfg_div),
    .cfg_start(cfg_start), .cfg_tap(cfg_tap),
    .clk_out(clk_out), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      cfg_en[i]             = (b_en[i] != 0);
      cfg_div[i*DW +: DW]   = DW'(b_div[i]);
      cfg_start[i*CW +: CW] = CW'(b_c[i]);
      cfg_tap[i*TW +: TW]   = TW'(b_k[i]);
    end
  end

  // model: tick counter and config snapshot taken on reset edges
  always @(posedge clk) begin
    if (rst) begin
      t <= -1;
      for (int i = 0; i < N_CH; i++) begin
        m_en[i] <= b_en[i]; m_div[i] <= b_div[i];
        m_c[i]  <= b_c[i];  m_k[i]   <= b_k[i];
      end
    end else t <= t + 1;
  end

  function automatic int eff_div(int ch);
    return (m_div[ch] == 0) ? 1 : m_div[ch];
  endfunction

  function automatic int wait_ticks(int ch);
    int c = (m_c[ch] == 0) ? 1 : m_c[ch];
    return (c - 1) * 8 + m_k[ch];
  endfunction

  function automatic int exp_out(int ch);
    int w = wait_ticks(ch);
    int d = eff_div(ch);
    if (m_en[ch] == 0 || t < w) return 0;
    return (((t - w) % (8 * d)) < (8 * ((d + 1) / 2))) ? 1 : 0;
  endfunction

  function automatic int exp_lock();
    int mx = 0;
    if (t < 0) return 0;
    for (int i = 0; i < N_CH; i++)
      if (m_en[i] != 0 && wait_ticks(i) > mx) mx = wait_ticks(i);
    return (t >= mx) ? 1 : 0;
  endfunction

  task automatic chk(string tag, logic act, int exp);
    n_chk++;
    if (act !== 1'(exp)) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %0d (tick %0d)", tag, act, exp, t);
    end
  endtask

  task automatic step(string scen);
    @(negedge clk);
    if (rst) begin
      for (int i = 0; i < N_CH; i++)
        chk($sformatf("R1 ch%0d low in reset", i), clk_out[i], 0);
      chk("R1 locked low in reset", locked, 0);
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        string r;
        if (m_en[i] == 0)                        r = "R7";
        else if (t < wait_ticks(i))              r = "R2";
        else if (t < wait_ticks(i) + 8*eff_div(i)) r = "R5";
        else                                     r = "R4";
        chk($sformatf("%s/%s ch%0d", scen, r, i), clk_out[i], exp_out(i));
      end
      chk($sformatf("%s/R8 locked", scen), locked, exp_lock());
    end
  endtask

  task automatic set_cfg(int en[N_CH], int dv[N_CH], int c[N_CH], int k[N_CH]);
    for (int i = 0; i < N_CH; i++) begin
      b_en[i] = en[i]; b_div[i] = dv[i]; b_c[i] = c[i]; b_k[i] = k[i];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // S1: R3 zero delay on ch0, taps 0..7, odd/even/unit divides, R2 coarse
    set_cfg('{1,1,1,1,1,1}, '{1,2,3,4,5,7}, '{1,1,2,3,1,4}, '{0,3,7,1,5,2});
    repeat (2) @(posedge clk);
    repeat (4) step("R1");
    rst = 1'b0;
    repeat (400) step("R3");
    // R9: inputs change mid-run, outputs must follow the snapshot
    set_cfg('{0,0,1,0,0,0}, '{9,1,1,1,1,1}, '{3,7,1,2,9,1}, '{6,6,6,6,6,6});
    repeat (200) step("R9");
    // R1 capture: garbage early in reset, real config at the last edges
    rst = 1'b1;
    set_cfg('{1,1,1,1,1,1}, '{3,3,3,3,3,3}, '{9,9,9,9,9,9}, '{1,1,1,1,1,1});
    repeat (2) step("R1");
    // R6 zero clamps, R7 disabled channels, R8 max delay among enabled
    set_cfg('{1,0,1,1,0,1}, '{0,6,1,2,8,3}, '{0,5,1,1,2,0}, '{7,0,0,6,1,4});
    repeat (2) step("R1");
    rst = 1'b0;
    repeat (300) step("R6");
    // R8 with every channel disabled: lock after tick 0
    rst = 1'b1;
    set_cfg('{0,0,0,0,0,0}, '{2,2,2,2,2,2}, '{4,4,4,4,4,4}, '{3,3,3,3,3,3});
    repeat (3) step("R1");
    rst = 1'b0;
    repeat (50) step("R8");
    // R2 at the largest coarse count, long period
    rst = 1'b1;
    set_cfg('{1,1,0,0,0,1}, '{255,2,1,1,1,1}, '{255,1,1,1,1,255}, '{7,0,0,0,0,0});
    repeat (3) step("R1");
    rst = 1'b0;
    repeat (6000) step("R2");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule